// File: doc/BRIEF.md
# Closest Clock Divider Level Search

This block picks, from a table of available source clock frequencies, the entry that comes closest to a requested frequency once it is divided by an integer. The divided result never exceeds the request. The table is held outside the block in ascending order, with up to `MAX_LEVELS` entries. The block reads it through a simple combinational read port, one entry at a time. A start pulse captures the requested frequency, an exact-only flag and the count of valid entries. A single-cycle done pulse then reports the chosen index, the chosen source frequency and an error flag.

For each entry the block needs two divisions. The first finds the integer divider, rounded up. The second finds the frequency that divider produces. Both divisions run on one shared restoring divider with a fixed latency. The search keeps the first entry with the strictly smallest shortfall. It stops as soon as an entry divides down to the request exactly. Callers that need an exact rate can ask the block to refuse anything less.

Top module: `clk_level_search`

## Requirements
- R1: For each entry F, the divider is ceil(F / request). It is computed from the quotient and the remainder, so it cannot overflow. A zero entry uses a divider of 1.
- R2: The shortfall of an entry is request minus floor(F / divider), so the chosen frequency divided by its divider never exceeds the request.
- R3: An entry replaces the current best only when its shortfall is strictly smaller. The best shortfall starts at all ones, so among equal shortfalls the lowest index is kept.
- R4: An entry with zero shortfall ends the search at once with err_o = 0. No table address above that entry is presented.
- R5: When exact_i was 1 at the start and no entry has zero shortfall, the done pulse carries err_o = 1 with best_idx_o = 0 and best_freq_o = 0.
- R6: When exact_i was 0, the done pulse carries err_o = 0 and the index and frequency of the best entry.
- R7: A start with level_count_i = 0 gives done_o = 1 and err_o = 1 in the next cycle, with index and frequency 0.
- R8: A start with req_freq_i = 0 gives done_o = 1 and err_o = 1 in the next cycle, with index and frequency 0, and no division is performed.
- R9: A level_count_i above MAX_LEVELS is treated as MAX_LEVELS. The table address never goes beyond the last valid entry.
- R10: done_o is high for one cycle and only when the block is idle. best_idx_o, best_freq_o and err_o change only together with done_o and hold until the next completion. A start_i during a search is ignored.
- R11: Entries are read in ascending address order from 0. tbl_data_i is sampled in the same cycle that tbl_addr_o presents the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a search (ignored while busy) |
| req_freq_i | input | FREQ_W | Requested frequency |
| exact_i | input | 1 | Accept only an exact divide result |
| level_count_i | input | $clog2(MAX_LEVELS+1) | Number of valid table entries |
| tbl_addr_o | output | $clog2(MAX_LEVELS) | Table read address |
| tbl_data_i | input | FREQ_W | Table read data for tbl_addr_o (same cycle) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Search failed (held until next completion) |
| best_idx_o | output | $clog2(MAX_LEVELS) | Chosen table index |
| best_freq_o | output | FREQ_W | Chosen source frequency |

## Verification
The bench sweeps the requested frequency over a small eight-entry table, with the exact flag both clear and set, and compares every result with a reference search computed arithmetically.

Ties in shortfall are set up on purpose, because a design that used a non-strict compare would return the later index. Exact hits in mid-table are covered too, and the bench checks that no higher address is read, because a design that did not stop early would still report the right entry but would waste reads. Zero requests, zero counts, a zero table entry and an over-range count are each driven. A design without those guards would hang, divide by zero, or read past the valid entries. Finally, a start pulse is injected in the middle of a search, which shows whether the design restarts when it must not.

// File: rtl/clk_lvl_pkg.sv
package clk_lvl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CEIL  = 2'd2,
        ST_QUOT  = 2'd3
    } lvl_state_t;

    // Outcome of evaluating one entry once its quotient is known.
    typedef struct packed {
        logic hit;   // zero shortfall
        logic last;  // final valid entry
        logic take;  // strictly better than the running best
    } lvl_verdict_t;

endpackage

// File: rtl/clk_lvl_div.sv
// Restoring unsigned divider: W cycles after start, done pulses with results.
module clk_lvl_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         done
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  quo_q, rem_q, dsr_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q, done_q;
    logic [W:0]    shifted;
    logic          ge;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        ge      = (shifted >= {1'b0, dsr_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q  <= '0;
            rem_q  <= '0;
            dsr_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                quo_q  <= dividend;
                rem_q  <= '0;
                dsr_q  <= divisor;
                cnt_q  <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (ge) begin
                    rem_q <= W'(shifted - {1'b0, dsr_q});
                end else begin
                    rem_q <= shifted[W-1:0];
                end
                quo_q <= {quo_q[W-2:0], ge};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(W - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign quo  = quo_q;
    assign rem  = rem_q;
    assign done = done_q;
endmodule

// File: rtl/clk_lvl_best.sv
// Running best entry: strict-less update keeps the lowest index on ties.
module clk_lvl_best #(
    parameter int W  = 32,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          load,
    input  logic [W-1:0]  cand_err,
    input  logic [IW-1:0] cand_idx,
    input  logic [W-1:0]  cand_freq,
    output logic          take,
    output logic [IW-1:0] best_idx,
    output logic [W-1:0]  best_freq
);
    logic [W-1:0]  err_q;
    logic [IW-1:0] idx_q;
    logic [W-1:0]  freq_q;

    assign take = (cand_err < err_q);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            err_q  <= '1;
            idx_q  <= '0;
            freq_q <= '0;
        end else if (load && take) begin
            err_q  <= cand_err;
            idx_q  <= cand_idx;
            freq_q <= cand_freq;
        end
    end

    assign best_idx  = idx_q;
    assign best_freq = freq_q;
endmodule

// File: rtl/clk_level_search.sv
module clk_level_search
    import clk_lvl_pkg::*;
#(
    parameter int FREQ_W     = 32,
    parameter int MAX_LEVELS = 32,
    localparam int IDX_W     = $clog2(MAX_LEVELS),
    localparam int CNT_W     = $clog2(MAX_LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] req_freq_i,
    input  logic              exact_i,
    input  logic [CNT_W-1:0]  level_count_i,
    output logic [IDX_W-1:0]  tbl_addr_o,
    input  logic [FREQ_W-1:0] tbl_data_i,
    output logic              done_o,
    output logic              err_o,
    output logic [IDX_W-1:0]  best_idx_o,
    output logic [FREQ_W-1:0] best_freq_o
);
    lvl_state_t        state_q;
    logic [IDX_W-1:0]  idx_q, last_q;
    logic [FREQ_W-1:0] req_q, ent_q;
    logic              exact_q;
    logic              done_q, err_q;
    logic [IDX_W-1:0]  res_idx_q;
    logic [FREQ_W-1:0] res_freq_q;

    logic              div_start, div_done;
    logic [FREQ_W-1:0] div_a, div_b, div_quo, div_rem;
    logic [FREQ_W-1:0] ceil_div, cand_err;
    logic [CNT_W-1:0]  cnt_c;
    logic              eval, tr_take, busy;
    logic [IDX_W-1:0]  tr_idx;
    logic [FREQ_W-1:0] tr_freq;
    lvl_verdict_t      vd;

    assign busy = (state_q != ST_IDLE);

    always_comb begin
        cnt_c = (level_count_i > CNT_W'(MAX_LEVELS)) ? CNT_W'(MAX_LEVELS) : level_count_i;
        // ceiling from quotient and remainder; a zero entry maps to divider 1
        ceil_div = div_quo + FREQ_W'(div_rem != '0);
        if (ceil_div == '0) ceil_div = FREQ_W'(1);
        div_start = (state_q == ST_FETCH) || (state_q == ST_CEIL && div_done);
        div_a     = (state_q == ST_FETCH) ? tbl_data_i : ent_q;
        div_b     = (state_q == ST_FETCH) ? req_q : ceil_div;
        eval      = (state_q == ST_QUOT) && div_done;
        cand_err  = req_q - div_quo;
        vd.hit    = (cand_err == '0);
        vd.last   = (idx_q == last_q);
        vd.take   = tr_take;
    end

    clk_lvl_div #(.W(FREQ_W)) u_div (
        .clk(clk), .rst(rst), .start(div_start),
        .dividend(div_a), .divisor(div_b),
        .quo(div_quo), .rem(div_rem), .done(div_done)
    );

    clk_lvl_best #(.W(FREQ_W), .IW(IDX_W)) u_best (
        .clk(clk), .rst(rst),
        .clear(!busy && start_i), .load(eval),
        .cand_err(cand_err), .cand_idx(idx_q), .cand_freq(ent_q),
        .take(tr_take), .best_idx(tr_idx), .best_freq(tr_freq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            last_q     <= '0;
            req_q      <= '0;
            ent_q      <= '0;
            exact_q    <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            res_idx_q  <= '0;
            res_freq_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    req_q   <= req_freq_i;
                    exact_q <= exact_i;
                    idx_q   <= '0;
                    if (req_freq_i == '0 || cnt_c == '0) begin
                        done_q     <= 1'b1;
                        err_q      <= 1'b1;
                        res_idx_q  <= '0;
                        res_freq_q <= '0;
                    end else begin
                        last_q  <= IDX_W'(cnt_c - 1'b1);
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    ent_q   <= tbl_data_i;
                    state_q <= ST_CEIL;
                end
                ST_CEIL: if (div_done) state_q <= ST_QUOT;
                ST_QUOT: if (div_done) begin
                    if (vd.hit) begin
                        done_q     <= 1'b1;
                        err_q      <= 1'b0;
                        res_idx_q  <= idx_q;
                        res_freq_q <= ent_q;
                        state_q    <= ST_IDLE;
                    end else if (vd.last) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                        if (exact_q) begin
                            err_q      <= 1'b1;
                            res_idx_q  <= '0;
                            res_freq_q <= '0;
                        end else begin
                            err_q      <= 1'b0;
                            res_idx_q  <= vd.take ? idx_q : tr_idx;
                            res_freq_q <= vd.take ? ent_q : tr_freq;
                        end
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign tbl_addr_o  = idx_q;
    assign done_o      = done_q;
    assign err_o       = err_q;
    assign best_idx_o  = res_idx_q;
    assign best_freq_o = res_freq_q;
endmodule

// File: rtl/clk_level_search_chk.sv
module clk_level_search_chk #(
    parameter int FREQ_W = 32,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [FREQ_W-1:0] req_freq_i,
    input logic [CNT_W-1:0]  level_count_i,
    input logic [IDX_W-1:0]  tbl_addr_o,
    input logic              done_o,
    input logic              err_o,
    input logic [IDX_W-1:0]  best_idx_o,
    input logic [FREQ_W-1:0] best_freq_o,
    input logic              busy,
    input logic [IDX_W-1:0]  last_q
);
    AST_ZERO_REQ_FAILS: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_i && req_freq_i == '0) |=> (done_o && err_o && !busy)); // R8

    AST_ZERO_COUNT_FAILS: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_i && level_count_i == '0) |=> (done_o && err_o && !busy)); // R7

    AST_ERR_CLEARS_RESULT: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> (best_idx_o == '0 && best_freq_o == '0)); // R5

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (tbl_addr_o <= last_q)); // R9

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy); // R10

    AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (!$stable(best_idx_o) || !$stable(best_freq_o) || !$stable(err_o)) |-> done_o); // R10

    AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (tbl_addr_o >= $past(tbl_addr_o))); // R11
endmodule

bind clk_level_search clk_level_search_chk #(
    .FREQ_W(FREQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .req_freq_i(req_freq_i),
    .level_count_i(level_count_i), .tbl_addr_o(tbl_addr_o),
    .done_o(done_o), .err_o(err_o), .best_idx_o(best_idx_o),
    .best_freq_o(best_freq_o), .busy(busy), .last_q(last_q)
);

// File: tb/tb_clk_level_search.sv
module tb_clk_level_search;
    localparam int CLK_PERIOD = 10;
    localparam int FREQ_W = 32;
    localparam int MAXL   = 32;
    localparam int IDX_W  = $clog2(MAXL);
    localparam int CNT_W  = $clog2(MAXL + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [FREQ_W-1:0] req_freq_i = '0;
    logic              exact_i = 1'b0;
    logic [CNT_W-1:0]  level_count_i = '0;
    logic [IDX_W-1:0]  tbl_addr_o;
    logic [FREQ_W-1:0] tbl_data_i;
    logic              done_o, err_o;
    logic [IDX_W-1:0]  best_idx_o;
    logic [FREQ_W-1:0] best_freq_o;

    logic [FREQ_W-1:0] tbl [MAXL];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign tbl_data_i = tbl[tbl_addr_o];

    clk_level_search #(.FREQ_W(FREQ_W), .MAX_LEVELS(MAXL)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .req_freq_i(req_freq_i),
        .exact_i(exact_i), .level_count_i(level_count_i),
        .tbl_addr_o(tbl_addr_o), .tbl_data_i(tbl_data_i),
        .done_o(done_o), .err_o(err_o),
        .best_idx_o(best_idx_o), .best_freq_o(best_freq_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void ref_search(input longint unsigned req, input bit exact,
                                       input int cnt, output bit e, output int idx,
                                       output longint unsigned f, output bit hit);
        longint unsigned best, fr, d, q, dl;
        int n;
        n = (cnt > MAXL) ? MAXL : cnt;
        e = 1'b0; idx = 0; f = 0; hit = 1'b0;
        if (req == 0 || n == 0) begin
            e = 1'b1;
            return;
        end
        best = 64'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            fr = tbl[i];
            d = (fr + req - 1) / req;
            if (d == 0) d = 1;
            q = fr / d;
            dl = req - q;
            if (dl < best) begin
                best = dl; idx = i; f = fr;
                if (dl == 0) begin
                    hit = 1'b1;
                    break;
                end
            end
        end
        if (!hit && exact) begin
            e = 1'b1; idx = 0; f = 0;
        end
    endfunction

    // Runs one search and compares against the reference.
    task automatic run(input logic [FREQ_W-1:0] req, input bit exact, input int cnt,
                       input bit poke, input string tag);
        bit e_exp, hit, mono;
        int i_exp, cyc, maxaddr, lastaddr, n;
        longint unsigned f_exp;
        logic [IDX_W-1:0] hold_idx;
        logic [FREQ_W-1:0] hold_freq;
        logic hold_err;
        ref_search(req, exact, cnt, e_exp, i_exp, f_exp, hit);
        n = (cnt > MAXL) ? MAXL : cnt;
        @(negedge clk);
        req_freq_i = req; exact_i = exact; level_count_i = CNT_W'(cnt); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1; maxaddr = 0; lastaddr = 0; mono = 1'b1;
        while (!done_o && cyc < 5000) begin
            if (int'(tbl_addr_o) < lastaddr) mono = 1'b0;
            lastaddr = int'(tbl_addr_o);
            if (lastaddr > maxaddr) maxaddr = lastaddr;
            if (poke && cyc == 10) begin
                start_i = 1'b1; req_freq_i = req + 3; exact_i = ~exact;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        chk(cyc < 5000, {tag, " R10 completion"}, cyc, 0);
        chk(err_o == e_exp, {tag, " err"}, err_o, e_exp);
        chk(int'(best_idx_o) == i_exp, {tag, " idx"}, best_idx_o, i_exp);
        chk(best_freq_o == f_exp, {tag, " freq"}, best_freq_o, f_exp);
        if (req == 0 || n == 0)
            chk(cyc == 1, {tag, " R7/R8 immediate latency"}, cyc, 1);
        else if (hit)
            chk(maxaddr == i_exp, {tag, " R4 early stop addr"}, maxaddr, i_exp);
        else
            chk(maxaddr == n - 1, {tag, " R9/R11 last addr"}, maxaddr, n - 1);
        chk(mono, {tag, " R11 ascending"}, mono, 1);
        hold_idx = best_idx_o; hold_freq = best_freq_o; hold_err = err_o;
        @(negedge clk);
        chk(!done_o, {tag, " R10 pulse width"}, done_o, 0);
        chk(best_idx_o == hold_idx && best_freq_o == hold_freq && err_o == hold_err,
            {tag, " R10 hold"}, best_idx_o, hold_idx);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tbl[0] = 7;  tbl[1] = 12; tbl[2] = 20; tbl[3] = 33;
        tbl[4] = 48; tbl[5] = 75; tbl[6] = 96; tbl[7] = 150;
        for (int i = 8; i < MAXL; i++) tbl[i] = 200 + 10 * i;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done_o && !err_o, "reset R10 flags", {done_o, err_o}, 0);
        chk(best_idx_o == 0 && best_freq_o == 0, "reset R10 result", best_freq_o, 0);

        // R1 R2 R3 R4 R5 R6: sweep over the request with both exact modes
        for (int r = 1; r <= 40; r++) begin
            run(r, 1'b0, 8, 1'b0, "sweep R1/R2/R3/R6");
            run(r, 1'b1, 8, 1'b0, "sweep R4/R5");
        end
        // shorter tables
        for (int c = 1; c <= 8; c++) run(23, 1'b0, c, 1'b0, "count R6");
        // R7, R8
        run(0, 1'b0, 8, 1'b0, "zero request R8");
        run(5, 1'b0, 0, 1'b0, "zero count R7");
        // R9: count beyond the table size is clamped
        run(61, 1'b0, 40, 1'b0, "clamp R9");
        run(1000, 1'b1, 63, 1'b0, "clamp exact R9");
        // R10: start during a search is ignored
        run(17, 1'b0, 8, 1'b1, "busy start R10");
        // R3: ties keep the lowest index
        tbl[0] = 9; tbl[1] = 14;
        run(4, 1'b0, 2, 1'b0, "tie R3");
        tbl[0] = 30; tbl[1] = 30;
        run(7, 1'b0, 2, 1'b0, "equal entries R3");
        // R1: zero entry uses divider 1
        tbl[0] = 0; tbl[1] = 12;
        run(5, 1'b0, 1, 1'b0, "zero entry R1");
        run(5, 1'b0, 2, 1'b0, "zero entry then better R1");
        // R2: large values near the top of the range
        tbl[0] = 32'hFFFF_FFF0; tbl[1] = 32'hFFFF_FFFF;
        run(32'h7FFF_FFFF, 1'b0, 2, 1'b0, "wide R2");
        run(32'hFFFF_FFFF, 1'b1, 2, 1'b0, "wide exact R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule